// File: doc/BRIEF.md
# SPI Slave Serial Front-End with Pause

This block is the serial edge of a memory-style SPI slave. It brings the SPI clock, the data input, the active-low select and an active-low pause input into a faster system clock through two-stage synchronisers. Edges are found on the synchronised copies. It works in SPI mode 0 and mode 3, with the system clock running at eight or more times the SPI clock. Data is sampled on SPI clock rising edges and driven on falling edges, most significant bit first, eight SPI clocks per byte.

Each completed byte appears on `rx_byte` with a one-cycle `rx_valid` strobe. At the first falling edge of every byte slot, the block captures `tx_byte`, signals the capture with a one-cycle `tx_req`, and shifts the byte out on the following falling edges. The command layer drives `tx_en` when it wants the serial output driven. The output enable is dropped while the slave is deselected, while a pause is active, and whenever `tx_en` is low.

A pause freezes the transfer in place and does not abort it. While the pause lasts, SPI clock and data are ignored and the output is released. The pause ends only when the pause input is high and the SPI clock is back at the level it had when the pause began. Every select falling edge re-aligns the bit counter. A frame that ends before eight bits have arrived produces no byte and never raises `opcode_seen`.

Top module: `spi_hold_frontend`

## Requirements
- R1: After synchronous reset, `rx_valid`, `tx_req`, `miso_oe_o`, `opcode_seen`, `frame_start` and `frame_end` are all 0.
- R2: Bits on `mosi_i` are sampled on SPI clock rising edges, first bit into bit 7. After the eighth rise, `rx_byte` holds the byte and `rx_valid` is high for exactly one cycle. This holds in mode 0 (clock idles low) and in mode 3 (clock idles high).
- R3: At an SPI clock falling edge where the bit count of the current byte is 0, `tx_byte` is captured, bit 7 is driven on `miso_o` and `tx_req` pulses for one cycle. Each later falling edge of the byte drives the next lower bit. In mode 0, a frame of two bytes therefore gives exactly two `tx_req` pulses.
- R4: While `sel_n_i` is high, SPI clock, data and pause activity produce no byte and no `tx_req`, and `miso_oe_o` stays 0.
- R5: Every falling edge of `sel_n_i` clears the bit count, so a partial byte from an earlier frame does not shift the next frame's bytes.
- R6: `opcode_seen` rises only after the first complete byte of a frame and is cleared at the next select falling edge. A frame closed after fewer than eight rises yields no `rx_valid` and leaves `opcode_seen` at 0.
- R7: A fall of `pause_n_i` while selected starts a pause. During the pause, SPI clock edges neither shift data nor advance the bit count. After the pause ends, reception continues within the same byte.
- R8: `miso_oe_o` is 0 for the whole pause and returns to 1 after it ends if `tx_en` is high.
- R9: A pause ends only when `pause_n_i` is high and the synchronised SPI clock equals the level it had when the pause started. A rise of `pause_n_i` while the clock is at the other level leaves the pause in force.
- R10: `miso_oe_o` is 1 only when selected, not paused and `tx_en` is 1.
- R11: `frame_start` pulses once per select falling edge, and `frame_end` pulses once per select rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SPI clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | SPI clock (asynchronous) |
| mosi_i | input | 1 | Serial data into the slave |
| sel_n_i | input | 1 | Active-low slave select |
| pause_n_i | input | 1 | Active-low pause |
| tx_en | input | 1 | Command layer requests output driving |
| tx_byte | input | DATA_W | Byte to send in the next byte slot |
| miso_o | output | 1 | Serial data out of the slave |
| miso_oe_o | output | 1 | Output enable for the pad tristate |
| rx_byte | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| tx_req | output | 1 | One-cycle strobe when `tx_byte` is captured |
| frame_start | output | 1 | Pulse on select falling edge |
| frame_end | output | 1 | Pulse on select rising edge |
| opcode_seen | output | 1 | A full first byte has arrived in this frame |

## Verification
The bench targets the points where a front-end most often slips.
- **Mode 3:** the first falling edge comes before any rising edge. A design that loads or counts there would misalign every byte.
- **Truncated frame:** a frame of five bits is followed by a full byte. A counter not cleared at select would merge the two into a wrong value.
- **Pause while clocking:** a pause with live clock edges would show extra bits if edges leak through.
- **Pause released at the wrong clock level:** a design that releases on the pause pin alone would enable the output early, and could count the edge that restores the clock level.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef struct packed {
    logic sclk;
    logic mosi;
    logic sel_n;
    logic pause_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sclk: 1'b0, mosi: 1'b0, sel_n: 1'b1, pause_n: 1'b1};
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= RST_VAL;
      else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst,
  input  logic selected,
  input  logic pause_n_s,
  input  logic pause_n_p,
  input  logic sclk_s,
  output logic paused,
  output logic pause_lvl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      paused    <= 1'b0;
      pause_lvl <= 1'b0;
    end else if (!selected) begin
      paused <= 1'b0;
    end else if (!paused) begin
      if (!pause_n_s && pause_n_p) begin
        paused    <= 1'b1;
        pause_lvl <= sclk_s;
      end
    end else if (pause_n_s && (sclk_s == pause_lvl)) begin
      paused <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          rise_ev,
  input  logic          fall_ev,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic          tx_req,
  output logic          miso,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] rx_sr;
  logic [DW-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr    <= '0;
      tx_sr    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      miso     <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      if (restart) begin
        bit_cnt <= '0;
      end else if (rise_ev) begin
        rx_sr <= {rx_sr[DW-2:0], mosi_s};
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          rx_byte  <= {rx_sr[DW-2:0], mosi_s};
          rx_valid <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (fall_ev) begin
        if (bit_cnt == '0) begin
          miso   <= tx_byte[DW-1];
          tx_sr  <= {tx_byte[DW-2:0], 1'b0};
          tx_req <= 1'b1;
        end else begin
          miso  <= tx_sr[DW-1];
          tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              sel_n_i,
  input  logic              pause_n_i,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              tx_req,
  output logic              frame_start,
  output logic              frame_end,
  output logic              opcode_seen
);
  import spi_fe_pkg::*;

  localparam int CNT_W  = $clog2(DATA_W);
  localparam int PINS_W = $bits(spi_pins_t);

  spi_pins_t pins_raw, pins_s;
  logic sclk_s, mosi_s, sel_n_s, pause_n_s;
  logic sclk_p, sel_n_p, pause_n_p;
  logic paused, pause_lvl;
  logic live, rise_ev, fall_ev;
  logic [CNT_W-1:0] bit_cnt;

  assign pins_raw = '{sclk: sclk_i, mosi: mosi_i, sel_n: sel_n_i, pause_n: pause_n_i};

  spi_fe_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  assign sclk_s    = pins_s.sclk;
  assign mosi_s    = pins_s.mosi;
  assign sel_n_s   = pins_s.sel_n;
  assign pause_n_s = pins_s.pause_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p    <= 1'b0;
      sel_n_p   <= 1'b1;
      pause_n_p <= 1'b1;
    end else begin
      sclk_p    <= sclk_s;
      sel_n_p   <= sel_n_s;
      pause_n_p <= pause_n_s;
    end
  end

  spi_fe_hold u_hold (
    .clk(clk), .rst(rst), .selected(!sel_n_s), .pause_n_s(pause_n_s),
    .pause_n_p(pause_n_p), .sclk_s(sclk_s), .paused(paused), .pause_lvl(pause_lvl)
  );

  assign live    = !sel_n_s && !paused && pause_n_s;
  assign rise_ev = live && sclk_s && !sclk_p;
  assign fall_ev = live && !sclk_s && sclk_p;

  spi_fe_shift #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .restart(!sel_n_s && sel_n_p),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .mosi_s(mosi_s), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req), .miso(miso_o),
    .bit_cnt(bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_oe_o   <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      opcode_seen <= 1'b0;
    end else begin
      miso_oe_o   <= live && tx_en;
      frame_start <= !sel_n_s && sel_n_p;
      frame_end   <= sel_n_s && !sel_n_p;
      if (!sel_n_s && sel_n_p) opcode_seen <= 1'b0;
      else if (rx_valid)       opcode_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n_s,
  input logic             sclk_s,
  input logic             paused,
  input logic             pause_lvl,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             rx_valid,
  input logic             opcode_seen,
  input logic             miso_oe_o
);
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_desel_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !miso_oe_o);

  p_opcode_after_byte_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(opcode_seen) |-> $past(rx_valid));

  p_pause_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    paused |=> $stable(bit_cnt));

  p_pause_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    paused |=> !miso_oe_o);

  p_release_level_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(paused) && !$past(sel_n_s)) |-> ($past(sclk_s) == $past(pause_lvl)));
endmodule

bind spi_hold_frontend spi_fe_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sel_n_s(sel_n_s), .sclk_s(sclk_s), .paused(paused),
  .pause_lvl(pause_lvl), .bit_cnt(bit_cnt), .rx_valid(rx_valid),
  .opcode_seen(opcode_seen), .miso_oe_o(miso_oe_o)
);

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 0, rst = 1;
  logic sclk = 0, mosi = 0, sel_n = 1, pause_n = 1, tx_en = 0;
  logic [7:0] tx_byte = 8'h00;
  logic miso, miso_oe, rx_valid, tx_req, frame_start, frame_end, opcode_seen;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0;
  int rx_cnt = 0, tx_cnt = 0, fs_cnt = 0, fe_cnt = 0;
  logic [7:0] rx_last = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_hold_frontend uut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .mosi_i(mosi), .sel_n_i(sel_n),
    .pause_n_i(pause_n), .tx_en(tx_en), .tx_byte(tx_byte), .miso_o(miso),
    .miso_oe_o(miso_oe), .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req),
    .frame_start(frame_start), .frame_end(frame_end), .opcode_seen(opcode_seen)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
    if (tx_req) tx_cnt++;
    if (frame_start) fs_cnt++;
    if (frame_end) fe_cnt++;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit: clock to low, present data, sample output, clock to high
  task automatic bit_clk(input logic b, output logic so, output logic oe);
    sclk = 0; mosi = b;
    waitc(HALF);
    so = miso; oe = miso_oe;
    sclk = 1;
    waitc(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic [7:0] got, output int oe_ones);
    logic so, oe;
    oe_ones = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(v[i], so, oe);
      got[i] = so;
      oe_ones += int'(oe);
    end
  endtask

  task automatic open_frame(input logic idle);
    sclk = idle; waitc(HALF);
    sel_n = 0; waitc(HALF);
  endtask

  task automatic close_frame(input logic idle);
    sclk = idle; waitc(HALF);
    sel_n = 1; waitc(HALF);
  endtask

  task automatic t_reset();
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 miso_oe", miso_oe, 0);
    chk("R1 opcode_seen", opcode_seen, 0);
    chk("R1 tx_req", tx_req, 0);
    chk("R1 frame pulses", frame_start | frame_end, 0);
  endtask

  task automatic t_mode0_rx();
    logic [7:0] g; int o; int c0 = rx_cnt; int f0 = fs_cnt; int e0 = fe_cnt;
    open_frame(0);
    chk("R6 opcode_seen low at start", opcode_seen, 0);
    send_byte(8'hC3, g, o); waitc(4);
    chk("R2 mode0 byte1", rx_last, 8'hC3);
    chk("R6 opcode_seen after byte", opcode_seen, 1);
    send_byte(8'h5A, g, o); waitc(4);
    chk("R2 mode0 byte2", rx_last, 8'h5A);
    chk("R2 strobe count", rx_cnt - c0, 2);
    close_frame(0);
    chk("R11 frame_start count", fs_cnt - f0, 1);
    chk("R11 frame_end count", fe_cnt - e0, 1);
  endtask

  task automatic t_mode3_rx();
    logic [7:0] g; int o; int c0 = rx_cnt;
    open_frame(1);
    send_byte(8'h96, g, o); waitc(4);
    chk("R2 mode3 byte", rx_last, 8'h96);
    chk("R2 mode3 count", rx_cnt - c0, 1);
    close_frame(1);
    sclk = 0; waitc(HALF);
  endtask

  task automatic t_tx();
    logic [7:0] g; int o; int t0 = tx_cnt;
    tx_en = 1; tx_byte = 8'hA5;
    open_frame(0);
    send_byte(8'h03, g, o);
    send_byte(8'h00, g, o);
    chk("R3 shifted byte", g, 8'hA5);
    chk("R10 oe during byte", o, 8);
    close_frame(0);
    chk("R3 tx_req count", tx_cnt - t0, 2);
    chk("R10 oe after deselect", miso_oe, 0);
    tx_en = 0;
  endtask

  task automatic t_deselect();
    logic so, oe; int c0 = rx_cnt; int t0 = tx_cnt; int oe_seen = 0;
    tx_en = 1;
    for (int i = 0; i < 16; i++) begin
      pause_n = i[1];
      bit_clk(i[0], so, oe);
      oe_seen += int'(oe);
    end
    pause_n = 1; sclk = 0; waitc(HALF);
    chk("R4 no byte while deselected", rx_cnt - c0, 0);
    chk("R4 no tx_req while deselected", tx_cnt - t0, 0);
    chk("R4 oe low while deselected", oe_seen, 0);
    tx_en = 0;
  endtask

  task automatic t_partial();
    logic so, oe; logic [7:0] g; int o; int c0 = rx_cnt;
    open_frame(0);
    for (int i = 0; i < 5; i++) bit_clk(1'b1, so, oe);
    close_frame(0);
    chk("R6 no byte on short frame", rx_cnt - c0, 0);
    chk("R6 opcode_seen stays low", opcode_seen, 0);
    open_frame(0);
    send_byte(8'h3C, g, o); waitc(4);
    chk("R5 realigned byte", rx_last, 8'h3C);
    chk("R5 one strobe", rx_cnt - c0, 1);
    close_frame(0);
  endtask

  task automatic t_hold_low();
    logic so, oe; int c0 = rx_cnt; logic [7:0] v = 8'hB2;
    tx_en = 1;
    open_frame(0);
    for (int i = 7; i >= 5; i--) bit_clk(v[i], so, oe);
    sclk = 0; waitc(HALF);
    pause_n = 0; waitc(HALF);
    chk("R8 oe low in pause", miso_oe, 0);
    for (int i = 0; i < 4; i++) bit_clk(i[0], so, oe);
    sclk = 0; waitc(HALF);
    chk("R7 no byte during pause", rx_cnt - c0, 0);
    pause_n = 1; waitc(HALF);
    chk("R8 oe back after pause", miso_oe, 1);
    for (int i = 4; i >= 0; i--) bit_clk(v[i], so, oe);
    waitc(4);
    chk("R7 byte resumes after pause", rx_last, 8'hB2);
    chk("R7 exactly one byte", rx_cnt - c0, 1);
    close_frame(0);
    tx_en = 0;
  endtask

  task automatic t_hold_level();
    logic so, oe; int c0 = rx_cnt; logic [7:0] v = 8'h6D;
    tx_en = 1;
    open_frame(0);
    for (int i = 7; i >= 4; i--) bit_clk(v[i], so, oe);
    pause_n = 0; waitc(HALF);
    sclk = 0; waitc(HALF);
    pause_n = 1; waitc(HALF);
    chk("R9 pause kept at other clock level", miso_oe, 0);
    sclk = 1; waitc(HALF);
    chk("R9 pause ends at matching level", miso_oe, 1);
    for (int i = 3; i >= 0; i--) bit_clk(v[i], so, oe);
    waitc(4);
    chk("R9 byte intact across pause", rx_last, 8'h6D);
    chk("R9 one byte", rx_cnt - c0, 1);
    close_frame(0);
    tx_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitc(5);
    rst = 0;
    waitc(2);
    t_reset();
    t_mode0_rx();
    t_mode3_rx();
    t_tx();
    t_deselect();
    t_partial();
    t_hold_low();
    t_hold_level();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule